// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block decodes one instruction of a small 32-bit machine whose instructions are one to six bytes long. Each cycle it receives the program counter and a six-byte window of instruction memory that starts at that counter. Byte 0 of the window is the first byte of the instruction. The block returns the fields that the execute stages need: class and function nibbles, two register specifiers, a 32-bit constant, the instruction length and the sequential successor address. It also raises a flag for encodings that are not legal, and it states whether a conditional jump is taken given the current overflow, zero and sign flags.

All results are captured in one output register stage, so they appear one clock after their inputs. Fetching the window, executing the instruction and accessing data memory are handled by neighbouring blocks.

The first byte holds the class in its upper nibble and the function in its lower nibble. The length follows from the class alone. Register specifier value 8 stands for "no register", and multi-byte constants are stored least-significant byte first.

Top module: `vlen_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output register clears to zero.
- R2: Each output reflects the `pc_i`, `win_i` and flag inputs that were present at the previous rising edge, and holds its value until the next edge.
- R3: `len_o` depends only on the class nibble (bits 7:4 of byte 0). Classes 0, 1, 9 and every unknown class give length 1. Classes 2, 6, 0xA and 0xB give length 2. Classes 7 and 8 give length 5. Classes 3, 4 and 5 give length 6.
- R4: `pc_next_o` equals the input PC plus `len_o`, wrapping modulo 2^32.
- R5: For classes 2, 3, 4, 5, 6, 0xA and 0xB, `ra_o` is bits 7:4 of byte 1 and `rb_o` is bits 3:0 of byte 1. For every other class, both are 8.
- R6: `valc_o` is bytes 2..5 read little-endian for classes 3, 4 and 5. It is bytes 1..4 read little-endian for classes 7 and 8. It is zero for every other class.
- R7: `invalid_o` is set when the function nibble is out of range. The legal range is 0..3 for class 6, 0..6 for class 7, and exactly 0 for every other known class.
- R8: Classes 0xC through 0xF set `invalid_o`.
- R9: `invalid_o` is set when a register slot that must hold 8 does not. This applies to `ra_o` for class 3 and to `rb_o` for classes 0xA and 0xB.
- R10: `take_o` is set only for a valid class 7 instruction whose condition holds. The conditions by function value are: 0 always; 1 (SF^OF)|ZF; 2 SF^OF; 3 ZF; 4 !ZF; 5 !(SF^OF); 6 !(SF^OF)&!ZF.
- R11: `icode_o` and `ifun_o` are the raw upper and lower nibbles of byte 0, including for invalid instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | Address of byte 0 of the window |
| win_i | input | 48 | Instruction bytes; byte k at bits 8k+7:8k |
| of_i | input | 1 | Overflow flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| icode_o | output | 4 | Class nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| valc_o | output | 32 | Assembled constant |
| len_o | output | 3 | Instruction length in bytes |
| pc_next_o | output | 32 | Sequential successor address |
| invalid_o | output | 1 | Illegal encoding |
| take_o | output | 1 | Jump condition satisfied |

## Verification
The embedded assertions check several properties on every cycle:
- the length is one of the four legal values;
- the successor address follows from the previous PC and the length;
- a taken jump is always a valid class 7 instruction;
- classes without a register byte report 8 in both register fields;
- classes without a constant report zero;
- unknown classes are flagged.

Other behaviour can only be shown by the bench's scenarios:
- the exact little-endian assembly of the constant at both byte offsets;
- each of the seven jump conditions under chosen flag values;
- the function-range and no-register checks that reject specific encodings;
- address wrap at the top of the space;
- the one-cycle latency.

// File: rtl/vdec_pkg.sv
// Package vdec_pkg
// Shared constants for the variable-length decoder: class codes, the
// "no register" specifier and the sizes of words and windows.
package vdec_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WIN_BYTES  = 6;
    localparam int WIN_W      = WIN_BYTES * 8;
    localparam int LEN_W      = $clog2(WIN_BYTES + 1);
    localparam int NIB_W      = 4;

    localparam logic [NIB_W-1:0] NO_REG = 4'h8;

    localparam logic [NIB_W-1:0] C_NOP   = 4'h0;
    localparam logic [NIB_W-1:0] C_HALT  = 4'h1;
    localparam logic [NIB_W-1:0] C_RRMOV = 4'h2;
    localparam logic [NIB_W-1:0] C_IRMOV = 4'h3;
    localparam logic [NIB_W-1:0] C_RMMOV = 4'h4;
    localparam logic [NIB_W-1:0] C_MRMOV = 4'h5;
    localparam logic [NIB_W-1:0] C_ALU   = 4'h6;
    localparam logic [NIB_W-1:0] C_JUMP  = 4'h7;
    localparam logic [NIB_W-1:0] C_CALL  = 4'h8;
    localparam logic [NIB_W-1:0] C_RET   = 4'h9;
    localparam logic [NIB_W-1:0] C_PUSH  = 4'hA;
    localparam logic [NIB_W-1:0] C_POP   = 4'hB;

    localparam logic [NIB_W-1:0] ALU_MAX_FUN  = 4'h3;
    localparam logic [NIB_W-1:0] JUMP_MAX_FUN = 4'h6;
endpackage

// File: rtl/vdec_len.sv
// Module vdec_len
// Maps the class nibble to an instruction length in bytes.
// Assumes unknown classes occupy one byte so that fetch can skip them.
module vdec_len
    import vdec_pkg::*;
(
    input  logic [NIB_W-1:0] icode,
    output logic [LEN_W-1:0] len
);
    // Length table indexed by class alone.
    always_comb begin
        case (icode)
            C_RRMOV, C_ALU, C_PUSH, C_POP: len = LEN_W'(2);
            C_JUMP, C_CALL:                len = LEN_W'(1 + WORD_BYTES);
            C_IRMOV, C_RMMOV, C_MRMOV:     len = LEN_W'(2 + WORD_BYTES);
            default:                       len = LEN_W'(1);
        endcase
    end
endmodule

// File: rtl/vdec_fields.sv
// Module vdec_fields
// Splits the window into class, function, register and constant fields
// and judges whether the encoding is legal. Purely combinational.
// Assumes byte k of the window sits at bits 8k+7:8k.
module vdec_fields
    import vdec_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    output logic [NIB_W-1:0] icode,
    output logic [NIB_W-1:0] ifun,
    output logic [NIB_W-1:0] ra,
    output logic [NIB_W-1:0] rb,
    output logic [WORD_W-1:0] valc,
    output logic             bad
);
    logic [7:0]        byte_q [WIN_BYTES];
    logic [WORD_W-1:0] const_at1;
    logic [WORD_W-1:0] const_at2;
    logic              has_regs;
    logic              fun_bad;
    logic              slot_bad;

    genvar gi;
    generate
        for (gi = 0; gi < WIN_BYTES; gi++) begin : g_bytes
            assign byte_q[gi] = win[8*gi +: 8];
        end
        for (gi = 0; gi < WORD_BYTES; gi++) begin : g_const
            assign const_at1[8*gi +: 8] = byte_q[1 + gi];
            assign const_at2[8*gi +: 8] = byte_q[2 + gi];
        end
    endgenerate

    assign icode = byte_q[0][7:4];
    assign ifun  = byte_q[0][3:0];

    // Classes that carry a register byte.
    always_comb begin
        case (icode)
            C_RRMOV, C_IRMOV, C_RMMOV, C_MRMOV,
            C_ALU, C_PUSH, C_POP: has_regs = 1'b1;
            default:              has_regs = 1'b0;
        endcase
    end

    // Register specifiers, or "no register" when the byte is absent.
    always_comb begin
        ra = has_regs ? byte_q[1][7:4] : NO_REG;
        rb = has_regs ? byte_q[1][3:0] : NO_REG;
    end

    // Constant selection by class.
    always_comb begin
        case (icode)
            C_IRMOV, C_RMMOV, C_MRMOV: valc = const_at2;
            C_JUMP, C_CALL:            valc = const_at1;
            default:                   valc = '0;
        endcase
    end

    // Function range and unknown-class check.
    always_comb begin
        case (icode)
            C_ALU:  fun_bad = (ifun > ALU_MAX_FUN);
            C_JUMP: fun_bad = (ifun > JUMP_MAX_FUN);
            C_NOP, C_HALT, C_RRMOV, C_IRMOV, C_RMMOV, C_MRMOV,
            C_CALL, C_RET, C_PUSH, C_POP: fun_bad = (ifun != '0);
            default: fun_bad = 1'b1;
        endcase
    end

    // Required no-register slots.
    always_comb begin
        case (icode)
            C_IRMOV:      slot_bad = (byte_q[1][7:4] != NO_REG);
            C_PUSH, C_POP: slot_bad = (byte_q[1][3:0] != NO_REG);
            default:      slot_bad = 1'b0;
        endcase
    end

    assign bad = fun_bad | slot_bad;
endmodule

// File: rtl/vdec_cond.sv
// Module vdec_cond
// Evaluates a jump condition from the function nibble and the flags.
// Assumes the caller gates the result with class and validity.
module vdec_cond
    import vdec_pkg::*;
(
    input  logic [NIB_W-1:0] ifun,
    input  logic             of_f,
    input  logic             zf_f,
    input  logic             sf_f,
    output logic             hold
);
    logic lt;
    assign lt = sf_f ^ of_f;

    // Condition table per function value.
    always_comb begin
        case (ifun)
            4'd0:    hold = 1'b1;
            4'd1:    hold = lt | zf_f;
            4'd2:    hold = lt;
            4'd3:    hold = zf_f;
            4'd4:    hold = ~zf_f;
            4'd5:    hold = ~lt;
            4'd6:    hold = ~lt & ~zf_f;
            default: hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/vlen_decoder.sv
// Module vlen_decoder
// Top of the decoder: combines length, field and condition logic and
// captures every result in one register stage (one-cycle latency).
// Assumes the window always holds six bytes starting at pc_i.
module vlen_decoder
    import vdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              of_i,
    input  logic              zf_i,
    input  logic              sf_i,
    output logic [NIB_W-1:0]  icode_o,
    output logic [NIB_W-1:0]  ifun_o,
    output logic [NIB_W-1:0]  ra_o,
    output logic [NIB_W-1:0]  rb_o,
    output logic [WORD_W-1:0] valc_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [WORD_W-1:0] pc_next_o,
    output logic              invalid_o,
    output logic              take_o
);
    logic [NIB_W-1:0]  d_icode, d_ifun, d_ra, d_rb;
    logic [WORD_W-1:0] d_valc, d_pc_next;
    logic [LEN_W-1:0]  d_len;
    logic              d_bad, d_hold, d_take;
    logic              live_q;

    vdec_fields u_fields (
        .win   (win_i),
        .icode (d_icode),
        .ifun  (d_ifun),
        .ra    (d_ra),
        .rb    (d_rb),
        .valc  (d_valc),
        .bad   (d_bad)
    );

    vdec_len u_len (
        .icode (d_icode),
        .len   (d_len)
    );

    vdec_cond u_cond (
        .ifun (d_ifun),
        .of_f (of_i),
        .zf_f (zf_i),
        .sf_f (sf_i),
        .hold (d_hold)
    );

    // Successor address and gated jump decision.
    always_comb begin
        d_pc_next = pc_i + WORD_W'(d_len);
        d_take    = (d_icode == C_JUMP) & ~d_bad & d_hold;
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icode_o   <= '0;
            ifun_o    <= '0;
            ra_o      <= '0;
            rb_o      <= '0;
            valc_o    <= '0;
            len_o     <= '0;
            pc_next_o <= '0;
            invalid_o <= 1'b0;
            take_o    <= 1'b0;
        end else begin
            icode_o   <= d_icode;
            ifun_o    <= d_ifun;
            ra_o      <= d_ra;
            rb_o      <= d_rb;
            valc_o    <= d_valc;
            len_o     <= d_len;
            pc_next_o <= d_pc_next;
            invalid_o <= d_bad;
            take_o    <= d_take;
        end
    end

    // Marks that the output stage holds a decoded instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (pc_next_o == $past(pc_i) + WORD_W'(len_o)));

    assert_take_only_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (icode_o == C_JUMP && !invalid_o));

    assert_no_reg_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (icode_o == C_NOP || icode_o == C_HALT || icode_o == C_JUMP ||
                    icode_o == C_CALL || icode_o == C_RET))
        |-> (ra_o == NO_REG && rb_o == NO_REG));

    assert_no_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_o == C_RRMOV || icode_o == C_ALU || icode_o == C_PUSH ||
         icode_o == C_POP || icode_o == C_RET || icode_o == C_HALT)
        |-> (valc_o == '0));

    assert_unknown_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_o >= 4'hC) |-> invalid_o);
endmodule

// File: tb/sim_vlen_decoder.sv
// Directed bench for vlen_decoder: one task per scenario.
module sim_vlen_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [47:0] win_i = '0;
    logic        of_i = 1'b0, zf_i = 1'b0, sf_i = 1'b0;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
    logic [31:0] valc_o, pc_next_o;
    logic [2:0]  len_o;
    logic        invalid_o, take_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_decoder u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .win_i(win_i),
        .of_i(of_i), .zf_i(zf_i), .sf_i(sf_i),
        .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
        .valc_o(valc_o), .len_o(len_o), .pc_next_o(pc_next_o),
        .invalid_o(invalid_o), .take_o(take_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one instruction at the falling edge, sample one falling edge later.
    task automatic issue(input logic [31:0] pc, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
                         input logic [7:0] b5);
        @(negedge clk);
        pc_i  = pc;
        win_i = {b5, b4, b3, b2, b1, b0};
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "icode", 32'(icode_o), 0);
        chk("R1", "len", 32'(len_o), 0);
        chk("R1", "pc_next", pc_next_o, 0);
        chk("R1", "invalid", 32'(invalid_o), 0);
        chk("R1", "take", 32'(take_o), 0);
    endtask

    task automatic t_nop();
        issue(32'h100, 8'h00, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99);
        chk("R11", "icode", 32'(icode_o), 0);
        chk("R3", "len", 32'(len_o), 1);
        chk("R4", "pc_next", pc_next_o, 32'h101);
        chk("R5", "ra", 32'(ra_o), 8);
        chk("R5", "rb", 32'(rb_o), 8);
        chk("R6", "valc", valc_o, 0);
        chk("R7", "invalid", 32'(invalid_o), 0);
    endtask

    task automatic t_alu();
        issue(32'h200, 8'h61, 8'h06, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        chk("R11", "ifun", 32'(ifun_o), 1);
        chk("R3", "len", 32'(len_o), 2);
        chk("R5", "ra", 32'(ra_o), 0);
        chk("R5", "rb", 32'(rb_o), 6);
        chk("R6", "valc", valc_o, 0);
        chk("R7", "invalid", 32'(invalid_o), 0);
        issue(32'h200, 8'h64, 8'h06, 0, 0, 0, 0);
        chk("R7", "alu fun 4 invalid", 32'(invalid_o), 1);
        chk("R11", "raw ifun", 32'(ifun_o), 4);
    endtask

    task automatic t_irmov();
        issue(32'h300, 8'h30, 8'h84, 8'h78, 8'h56, 8'h34, 8'h12);
        chk("R6", "valc", valc_o, 32'h12345678);
        chk("R3", "len", 32'(len_o), 6);
        chk("R4", "pc_next", pc_next_o, 32'h306);
        chk("R5", "rb", 32'(rb_o), 4);
        chk("R9", "valid", 32'(invalid_o), 0);
        issue(32'h300, 8'h30, 8'h24, 8'h78, 8'h56, 8'h34, 8'h12);
        chk("R9", "ra not 8", 32'(invalid_o), 1);
    endtask

    task automatic t_mrmov();
        issue(32'h40, 8'h50, 8'h13, 8'h04, 8'h00, 8'h00, 8'h80);
        chk("R6", "valc", valc_o, 32'h80000004);
        chk("R5", "ra", 32'(ra_o), 1);
        chk("R5", "rb", 32'(rb_o), 3);
        chk("R7", "invalid", 32'(invalid_o), 0);
    endtask

    task automatic t_jump_wrap();
        issue(32'hFFFF_FFFE, 8'h70, 8'h00, 8'h01, 8'h00, 8'h00, 8'hAA);
        chk("R3", "len", 32'(len_o), 5);
        chk("R4", "wrap", pc_next_o, 32'h3);
        chk("R6", "valc", valc_o, 32'h100);
        chk("R10", "jmp take", 32'(take_o), 1);
        chk("R5", "ra", 32'(ra_o), 8);
    endtask

    task automatic t_cond(input logic [3:0] fun, input logic o, input logic z,
                          input logic s, input logic exp);
        of_i = o; zf_i = z; sf_i = s;
        issue(32'h10, {4'h7, fun}, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00);
        chk("R10", $sformatf("cond fun %0d", fun), 32'(take_o), 32'(exp));
    endtask

    task automatic t_conds();
        t_cond(4'd1, 0, 1, 0, 1);
        t_cond(4'd1, 1, 0, 1, 0);
        t_cond(4'd2, 0, 0, 1, 1);
        t_cond(4'd2, 1, 0, 1, 0);
        t_cond(4'd3, 0, 1, 0, 1);
        t_cond(4'd4, 0, 1, 0, 0);
        t_cond(4'd4, 0, 0, 0, 1);
        t_cond(4'd5, 1, 0, 1, 1);
        t_cond(4'd5, 1, 0, 0, 0);
        t_cond(4'd6, 0, 1, 0, 0);
        t_cond(4'd6, 0, 0, 0, 1);
        t_cond(4'd7, 0, 0, 0, 0);
        chk("R7", "jump fun 7 invalid", 32'(invalid_o), 1);
        of_i = 0; zf_i = 0; sf_i = 0;
    endtask

    task automatic t_call_ret();
        issue(32'h500, 8'h80, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h00);
        chk("R6", "call valc", valc_o, 32'hDEADBEEF);
        chk("R10", "call no take", 32'(take_o), 0);
        chk("R4", "call pc_next", pc_next_o, 32'h505);
        issue(32'h500, 8'h91, 0, 0, 0, 0, 0);
        chk("R7", "ret fun 1 invalid", 32'(invalid_o), 1);
        chk("R3", "ret len", 32'(len_o), 1);
    endtask

    task automatic t_push_pop();
        issue(32'h600, 8'hA0, 8'h38, 0, 0, 0, 0);
        chk("R5", "push ra", 32'(ra_o), 3);
        chk("R9", "push valid", 32'(invalid_o), 0);
        chk("R3", "push len", 32'(len_o), 2);
        issue(32'h600, 8'hB0, 8'h34, 0, 0, 0, 0);
        chk("R9", "pop rb not 8", 32'(invalid_o), 1);
    endtask

    task automatic t_unknown();
        issue(32'h700, 8'hC0, 8'h12, 0, 0, 0, 0);
        chk("R8", "unknown invalid", 32'(invalid_o), 1);
        chk("R3", "unknown len", 32'(len_o), 1);
        chk("R11", "unknown icode", 32'(icode_o), 32'hC);
    endtask

    task automatic t_latency();
        issue(32'h800, 8'h20, 8'h12, 0, 0, 0, 0);
        @(negedge clk);
        win_i = {40'h0, 8'h10};
        #1;
        chk("R2", "held before edge", 32'(icode_o), 2);
        @(negedge clk);
        chk("R2", "updated after edge", 32'(icode_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nop();
        t_alu();
        t_irmov();
        t_mrmov();
        t_jump_wrap();
        t_conds();
        t_call_ret();
        t_push_pop();
        t_unknown();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule